// File: doc/BRIEF.md
# Processor Power Mode Controller

This block steps a processor core between four power states: full power, doze, nap and sleep. Software asks for a low-power state by writing a one-hot mode field. The request is honoured only while the core runs in full power. From any low-power state the only way out is back to full power, through a wake event.

Doze keeps bus snooping alive. A snoop hit in doze briefly turns the data cache on for a copy-back, then the core settles back into doze. Nap and sleep switch snooping off, so the controller first raises a quiesce request toward the system bus. It enters the deeper state only once that request is acknowledged.

A down-counting decrementer runs in every state except sleep, and its expiry is one of the wake sources. In full power, a separate level input turns on demand-driven clock gating, so each functional unit is clocked only while it has work dispatched to it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, `cur_mode` is 0 (full power) and `mode_err` is 0. `quiesce_req` and `copyback_req` are low, `snoop_en`, `dcache_en` and `dec_clk_en` are high, and `unit_clk_en` is all ones.
- R2: `cur_mode` encodes the state as 0 for full power, 1 for doze, 2 for nap and 3 for sleep. In `mode_wdata`, bit 0 selects doze, bit 1 selects nap and bit 2 selects sleep. A `mode_wr` pulse in full power carrying exactly one set bit has the following effect at the next clock edge: doze selects doze, and nap or sleep raises `quiesce_req` while `cur_mode` stays 0.
- R3: A `mode_wr` in full power with zero bits or more than one bit set leaves the state unchanged and sets `mode_err`. The flag then stays set until reset.
- R4: A `mode_wr` in any low-power state is ignored, so no low-power state ever moves straight to another one.
- R5: Nap or sleep is entered one edge after `quiesce_ack` is seen while `quiesce_req` is high. A wake event during the handshake drops `quiesce_req` and returns to full power, and it wins over an acknowledge in the same cycle.
- R6: `snoop_en` is low only in nap and sleep. `dcache_en` is high in full power, during the handshake and during a copy-back, and low otherwise.
- R7: `snoop_hit` in doze raises `copyback_req` and `dcache_en` until `copyback_done`, then returns to doze. If a wake arrives together with the hit, the wake wins. A wake that arrives during a copy-back is held, and the controller goes to full power when `copyback_done` comes.
- R8: In doze and nap, `ext_irq`, `smi_irq` or a decrementer expiry returns the core to full power at the next edge.
- R9: In sleep the decrementer holds its count and `dec_clk_en` is low. Only `ext_irq` or `smi_irq` wake the core.
- R10: `dec_load` loads `dec_value`. The counter then decrements once per cycle while running. If V is loaded at edge 0, `dec_irq` is high for exactly one cycle after edge V+1, the edge at which the count wraps from 0 to all ones. Reset loads all ones.
- R11: `unit_clk_en` is all ones in full power with `dyn_gate_en` low, and equals `unit_busy` with `dyn_gate_en` high. It is all zeros in doze, nap and sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | One-hot mode request (doze, nap, sleep) |
| dyn_gate_en | input | 1 | Demand-driven clock gating enable in full power |
| unit_busy | input | N_UNITS | Per-unit work-dispatched flags |
| ext_irq | input | 1 | External asynchronous interrupt |
| smi_irq | input | 1 | System-management interrupt |
| dec_load | input | 1 | Decrementer load strobe |
| dec_value | input | DEC_W | Decrementer load value |
| quiesce_ack | input | 1 | Bus acknowledge of coherency quiesce |
| snoop_hit | input | 1 | Snoop hit while dozing |
| copyback_done | input | 1 | Copy-back finished |
| cur_mode | output | 2 | Current power state code |
| quiesce_req | output | 1 | Coherency quiesce request |
| snoop_en | output | 1 | Bus snooping enable |
| dcache_en | output | 1 | Data cache enable |
| copyback_req | output | 1 | Copy-back request |
| dec_clk_en | output | 1 | Decrementer running |
| unit_clk_en | output | N_UNITS | Per-unit clock enables |
| dec_irq | output | 1 | One-cycle decrementer expiry pulse |
| mode_err | output | 1 | Sticky illegal mode write flag |

## Verification
Two events can land in the same cycle: a wake and an acknowledge of the quiesce handshake, or a wake and a snoop hit while dozing. Both pairs are placed on one clock edge in the vector table. The check expects full power with no copy-back, which shows that the wake took priority. A third case raises a wake in the middle of a copy-back, and the check expects that wake to take effect only on the done strobe.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int MODE_W   = 3;
  localparam int MB_DOZE  = 0;
  localparam int MB_NAP   = 1;
  localparam int MB_SLEEP = 2;

  typedef enum logic [2:0] {
    ST_FULL     = 3'd0,
    ST_QUIESCE  = 3'd1,
    ST_DOZE     = 3'd2,
    ST_COPYBACK = 3'd3,
    ST_NAP      = 3'd4,
    ST_SLEEP    = 3'd5
  } pm_state_e;

  localparam logic [1:0] CODE_FULL  = 2'd0;
  localparam logic [1:0] CODE_DOZE  = 2'd1;
  localparam logic [1:0] CODE_NAP   = 2'd2;
  localparam logic [1:0] CODE_SLEEP = 2'd3;
endpackage

// File: rtl/pm_decrementer.sv
module pm_decrementer #(
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [DEC_W-1:0] load_val,
  output logic             irq
);
  localparam logic [DEC_W-1:0] ALL_ONES = {DEC_W{1'b1}};

  logic [DEC_W-1:0] cnt_q;
  logic             irq_q;
  logic             wrap;

  assign wrap = run && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ALL_ONES;
      irq_q <= 1'b0;
    end else begin
      irq_q <= wrap;
      if (load)     cnt_q <= load_val;
      else if (run) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign irq = irq_q;

  assert_wrap_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q == '0) |=> (irq && cnt_q == ALL_ONES));

  assert_frozen_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              ext_irq,
  input  logic              smi_irq,
  input  logic              dec_irq,
  input  logic              quiesce_ack,
  input  logic              snoop_hit,
  input  logic              copyback_done,
  output logic [1:0]        cur_mode,
  output logic              quiesce_req,
  output logic              snoop_en,
  output logic              dcache_en,
  output logic              copyback_req,
  output logic              core_on,
  output logic              dec_run,
  output logic              mode_err
);
  pm_state_e state_q, state_d;
  pm_state_e tgt_q, tgt_d;
  logic      pend_q, pend_d;
  logic      err_q;
  logic      legal, wake_any, wake_ext, bad_wr;

  assign legal    = ($countones(mode_wdata) == 1);
  assign wake_ext = ext_irq | smi_irq;
  assign wake_any = wake_ext | dec_irq;
  assign bad_wr   = (state_q == ST_FULL) && mode_wr && !legal;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    pend_d  = 1'b0;
    unique case (state_q)
      ST_FULL: if (mode_wr && legal) begin
        if (mode_wdata[MB_DOZE]) state_d = ST_DOZE;
        else begin
          state_d = ST_QUIESCE;
          tgt_d   = mode_wdata[MB_NAP] ? ST_NAP : ST_SLEEP;
        end
      end
      ST_QUIESCE:  if (wake_any) state_d = ST_FULL;
                   else if (quiesce_ack) state_d = tgt_q;
      ST_DOZE:     if (wake_any) state_d = ST_FULL;
                   else if (snoop_hit) state_d = ST_COPYBACK;
      ST_COPYBACK: begin
        pend_d = pend_q | wake_any;
        if (copyback_done) begin
          state_d = (pend_q || wake_any) ? ST_FULL : ST_DOZE;
          pend_d  = 1'b0;
        end
      end
      ST_NAP:      if (wake_any) state_d = ST_FULL;
      ST_SLEEP:    if (wake_ext) state_d = ST_FULL;
      default:     state_d = ST_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FULL;
      tgt_q   <= ST_NAP;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      pend_q  <= pend_d;
      if (bad_wr) err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_DOZE, ST_COPYBACK: cur_mode = CODE_DOZE;
      ST_NAP:               cur_mode = CODE_NAP;
      ST_SLEEP:             cur_mode = CODE_SLEEP;
      default:              cur_mode = CODE_FULL;
    endcase
  end

  assign core_on      = (state_q == ST_FULL) || (state_q == ST_QUIESCE);
  assign quiesce_req  = (state_q == ST_QUIESCE);
  assign copyback_req = (state_q == ST_COPYBACK);
  assign snoop_en     = !((state_q == ST_NAP) || (state_q == ST_SLEEP));
  assign dcache_en    = core_on || (state_q == ST_COPYBACK);
  assign dec_run      = (state_q != ST_SLEEP);
  assign mode_err     = err_q;

  assert_no_direct_hop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NAP || state_q == ST_SLEEP) |=>
      (state_q == $past(state_q) || state_q == ST_FULL));

  assert_deep_from_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FULL || state_q == ST_DOZE || state_q == ST_COPYBACK) |=>
      !(state_q == ST_NAP || state_q == ST_SLEEP));

  assert_deep_needs_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_QUIESCE && !quiesce_ack) |=>
      !(state_q == ST_NAP || state_q == ST_SLEEP));

  assert_sleep_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !ext_irq && !smi_irq) |=> (state_q == ST_SLEEP));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);
endmodule

// File: rtl/pm_clk_gate.sv
module pm_clk_gate #(
  parameter int N_UNITS = 4
) (
  input  logic               core_on,
  input  logic               dyn_gate_en,
  input  logic [N_UNITS-1:0] unit_busy,
  output logic [N_UNITS-1:0] unit_clk_en
);
  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    assign unit_clk_en[u] = core_on && (!dyn_gate_en || unit_busy[u]);
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pm_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int DEC_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic [MODE_W-1:0]  mode_wdata,
  input  logic               dyn_gate_en,
  input  logic [N_UNITS-1:0] unit_busy,
  input  logic               ext_irq,
  input  logic               smi_irq,
  input  logic               dec_load,
  input  logic [DEC_W-1:0]   dec_value,
  input  logic               quiesce_ack,
  input  logic               snoop_hit,
  input  logic               copyback_done,
  output logic [1:0]         cur_mode,
  output logic               quiesce_req,
  output logic               snoop_en,
  output logic               dcache_en,
  output logic               copyback_req,
  output logic               dec_clk_en,
  output logic [N_UNITS-1:0] unit_clk_en,
  output logic               dec_irq,
  output logic               mode_err
);
  logic core_on;
  logic dec_run;

  pm_decrementer #(.DEC_W(DEC_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (dec_run),
    .load     (dec_load),
    .load_val (dec_value),
    .irq      (dec_irq)
  );

  pm_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_wr       (mode_wr),
    .mode_wdata    (mode_wdata),
    .ext_irq       (ext_irq),
    .smi_irq       (smi_irq),
    .dec_irq       (dec_irq),
    .quiesce_ack   (quiesce_ack),
    .snoop_hit     (snoop_hit),
    .copyback_done (copyback_done),
    .cur_mode      (cur_mode),
    .quiesce_req   (quiesce_req),
    .snoop_en      (snoop_en),
    .dcache_en     (dcache_en),
    .copyback_req  (copyback_req),
    .core_on       (core_on),
    .dec_run       (dec_run),
    .mode_err      (mode_err)
  );

  pm_clk_gate #(.N_UNITS(N_UNITS)) u_gate (
    .core_on     (core_on),
    .dyn_gate_en (dyn_gate_en),
    .unit_busy   (unit_busy),
    .unit_clk_en (unit_clk_en)
  );

  assign dec_clk_en = dec_run;

  assert_gate_off_low_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != CODE_FULL) |-> (unit_clk_en == '0));

  assert_snoop_off_deep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == CODE_NAP || cur_mode == CODE_SLEEP) |-> (!snoop_en && !dcache_en));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int CLK_P   = 10;
  localparam int N_UNITS = 4;
  localparam int DEC_W   = 32;
  localparam int N_VEC   = 25;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               mode_wr = 1'b0;
  logic [2:0]         mode_wdata = '0;
  logic               dyn_gate_en = 1'b0;
  logic [N_UNITS-1:0] unit_busy = '0;
  logic               ext_irq = 1'b0, smi_irq = 1'b0;
  logic               dec_load = 1'b0;
  logic [DEC_W-1:0]   dec_value = '0;
  logic               quiesce_ack = 1'b0, snoop_hit = 1'b0, copyback_done = 1'b0;
  logic [1:0]         cur_mode;
  logic               quiesce_req, snoop_en, dcache_en, copyback_req, dec_clk_en;
  logic [N_UNITS-1:0] unit_clk_en;
  logic               dec_irq, mode_err;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_mode_ctrl #(.N_UNITS(N_UNITS), .DEC_W(DEC_W)) u_pwr_mode_ctrl (.*);

  // in: {wr, data[2:0], ext, smi, ack, hit, done}
  // out: {mode[1:0], qreq, snoop, dcache, cbreq, err}
  localparam logic [15:0] VEC [0:N_VEC-1] = '{
    16'b1_001_00000_01_0_1_0_0_0, // R2 enter doze
    16'b0_000_00000_01_0_1_0_0_0, // R2 idle in doze
    16'b0_000_00010_01_0_1_1_1_0, // R7 snoop hit
    16'b0_000_00000_01_0_1_1_1_0, // R7 copy-back pending
    16'b0_000_00001_01_0_1_0_0_0, // R7 done, back to doze
    16'b1_010_00000_01_0_1_0_0_0, // R4 write ignored in doze
    16'b0_000_10000_00_0_1_1_0_0, // R8 ext wakes doze
    16'b1_010_00000_00_1_1_1_0_0, // R5 nap request
    16'b0_000_00000_00_1_1_1_0_0, // R5 waiting ack
    16'b0_000_00100_10_0_0_0_0_0, // R5 ack, nap; R6 snoop off
    16'b0_000_00000_10_0_0_0_0_0, // R6 nap idle
    16'b0_000_01000_00_0_1_1_0_0, // R8 smi wakes nap
    16'b1_011_00000_00_0_1_1_0_1, // R3 two bits set
    16'b1_100_00000_00_1_1_1_0_1, // R2 sleep request
    16'b0_000_10100_00_0_1_1_0_1, // R5 ack with wake, wake wins
    16'b1_100_00000_00_1_1_1_0_1, // R2 sleep request again
    16'b0_000_00100_11_0_0_0_0_1, // R5 sleep entered
    16'b0_000_10000_00_0_1_1_0_1, // R9 ext wakes sleep
    16'b1_000_00000_00_0_1_1_0_1, // R3 zero bits
    16'b1_001_00000_01_0_1_0_0_1, // R2 doze
    16'b0_000_10010_00_0_1_1_0_1, // R7 hit with wake, wake wins
    16'b1_001_00000_01_0_1_0_0_1, // R2 doze
    16'b0_000_00010_01_0_1_1_1_1, // R7 hit
    16'b0_000_10000_01_0_1_1_1_1, // R7 wake held during copy-back
    16'b0_000_00001_00_0_1_1_0_1  // R7 done with held wake -> full
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic clear_pulses();
    mode_wr = 0; mode_wdata = '0; ext_irq = 0; smi_irq = 0; quiesce_ack = 0;
    snoop_hit = 0; copyback_done = 0; dec_load = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 reset outputs",
          {cur_mode, quiesce_req, copyback_req, snoop_en, dcache_en, dec_clk_en, dec_irq, mode_err},
          {2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
    check("R1 reset unit clocks", unit_clk_en, {N_UNITS{1'b1}});

    for (int i = 0; i < N_VEC; i++) begin
      {mode_wr, mode_wdata, ext_irq, smi_irq, quiesce_ack, snoop_hit, copyback_done} = VEC[i][15:7];
      tick();
      check($sformatf("vector %0d", i),
            {cur_mode, quiesce_req, snoop_en, dcache_en, copyback_req, mode_err}, VEC[i][6:0]);
      clear_pulses();
    end

    // R3 error flag cleared only by reset
    do_reset();
    check("R3 err cleared by reset", mode_err, 1'b0);

    // R11 clock gating
    dyn_gate_en = 1'b1; unit_busy = 4'b0101; #1;
    check("R11 gated by busy", unit_clk_en, 4'b0101);
    unit_busy = 4'b1010; #1;
    check("R11 gated follows busy", unit_clk_en, 4'b1010);
    mode_wr = 1; mode_wdata = 3'b001; tick(); clear_pulses();
    check("R11 doze gates all off", unit_clk_en, 4'b0000);
    ext_irq = 1; tick(); clear_pulses();
    dyn_gate_en = 1'b0; #1;
    check("R11 ungated all on", unit_clk_en, 4'b1111);

    // R10 decrementer timing: load 3
    dec_load = 1; dec_value = 32'd3; tick(); clear_pulses();
    for (int k = 1; k <= 3; k++) begin
      tick();
      check("R10 no pulse before wrap", dec_irq, 1'b0);
    end
    tick();
    check("R10 pulse at wrap", dec_irq, 1'b1);
    tick();
    check("R10 pulse one cycle", dec_irq, 1'b0);

    // R8 decrementer wakes nap
    dec_load = 1; dec_value = 32'd3; tick(); clear_pulses();
    mode_wr = 1; mode_wdata = 3'b010; tick(); clear_pulses();
    quiesce_ack = 1; tick(); clear_pulses();
    check("R8 in nap", cur_mode, 2'd2);
    tick();
    tick();
    check("R8 nap before expiry", {cur_mode, dec_irq}, {2'd2, 1'b1});
    tick();
    check("R8 decrementer woke nap", cur_mode, 2'd0);

    // R9 sleep freezes decrementer
    dec_load = 1; dec_value = 32'd2; tick(); clear_pulses();
    mode_wr = 1; mode_wdata = 3'b100; tick(); clear_pulses();
    quiesce_ack = 1; tick(); clear_pulses();
    check("R9 in sleep, decrementer stopped", {cur_mode, dec_clk_en}, {2'd3, 1'b0});
    begin
      int seen = 0;
      for (int k = 0; k < 12; k++) begin
        tick();
        if (dec_irq || cur_mode != 2'd3) seen++;
      end
      check("R9 sleep held, no expiry", seen, 0);
    end
    ext_irq = 1; tick(); clear_pulses();
    check("R9 ext wakes sleep", {cur_mode, dec_irq}, {2'd0, 1'b0});
    tick();
    check("R9 frozen count resumes at zero", dec_irq, 1'b1);

    summary();
  end
endmodule